// File: doc/BRIEF.md
# PLL Bring-up Calibrator with Lock Qualification

This block brings the ATA-side PLL up from the bus clock. When it accepts a start request, it captures a frequency-count word measured from the bus clock and sorts the bus into one of four frequency bands. From that band it derives the lower and upper bounds of the PLL frequency window and the 66 MHz flag. It then raises the tuning enable and runs calibration attempts.

Each attempt polls the raw lock bit at a fixed interval until the bit appears. Once it appears, the lock must hold on every clock for a confirmation window. If the PLL never locks, or the lock drops during confirmation, the attempt fails and the tuning enable is dropped for the rest of the run. After a confirmed lock, or once the attempt budget is used up, the block reports the outcome. That outcome stays on the outputs until the next start.

The analog loop and the configuration access that carries the window to it sit outside the block.

Top module: `pll_lock_qualifier`

## Requirements
- R1: After reset, every output is zero: busy_o, done_o, pass_o, tune_en_o, band_mhz_o, fast_bus_o, win_low_o and win_high_o.
- R2: When count bits [31:12] differ from 20'hABCDE, the band is 33.
- R3: When the signature in R2 matches, the frequency is (count bits [8:0] × 77) / 192, using integer division. The band is then 33 below 40, 40 below 45, 50 below 55, and 66 otherwise.
- R4: On the clock edge that accepts a start, the outputs take these values: win_low_o = band × 48 / 66 (integer), win_high_o = win_low_o + 2, and fast_bus_o = 1 exactly when the band exceeds 60.
- R5: tune_en_o rises on an accepted start. It falls on the first failed attempt and on a confirmed lock, and it stays low until the next start.
- R6: In the searching phase, lock_raw_i is sampled once every POLL_INTERVAL clocks. The first sample comes POLL_INTERVAL clocks after the start edge or after a failed attempt. An attempt fails when LOCK_WAIT_POLLS consecutive samples are all low.
- R7: After a sample sees lock, lock_raw_i is sampled on each of the next HOLD_SAMPLES clocks. Any low sample fails the attempt. If all of them are high, the edge of the last sample sets done_o and pass_o.
- R8: At most MAX_ATTEMPTS attempts run. When the last one fails, done_o = 1 and pass_o = 0.
- R9: busy_o is high from the accepted start until the result is reported. A start seen while busy_o is high is ignored, and the band and window stay unchanged. The result outputs hold until the next accepted start, which clears done_o and pass_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| count_word_i | input | 32 | Measured bus-clock count with signature field |
| lock_raw_i | input | 1 | Raw PLL lock indication |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Result valid |
| pass_o | output | 1 | Lock confirmed (valid with done_o) |
| tune_en_o | output | 1 | Tuning enable for the window register |
| band_mhz_o | output | 7 | Selected bus band in MHz |
| fast_bus_o | output | 1 | Band above 60 MHz |
| win_low_o | output | 8 | Lower window bound |
| win_high_o | output | 8 | Upper window bound |

## Verification
The hardest situations to produce from the ports are those where timing sits exactly on a limit. One is a lock that first appears on the very last poll of an attempt. Another is a lock that appears one clock too late, so the next attempt catches it. A third is a lock that holds for all confirmation samples but one.

The bench reaches these by driving lock_raw_i as a function of the clock count since the start pulse. The on and off points are chosen from the poll schedule, and a behavioural model tracks the expected state on every clock. Band boundaries are reached by picking count values whose scaled frequencies land at 39/40, 44/45 and 54/55.

// File: rtl/pll_cal_pkg.sv
package pll_cal_pkg;

    localparam logic [19:0] COUNT_SIGNATURE = 20'hABCDE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEEK = 2'd1,
        ST_HOLD = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic [6:0] mhz;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       fast;
    } band_info_t;

    function automatic logic [6:0] pick_band(input logic [19:0] sig,
                                             input logic [8:0]  cnt);
        logic [15:0] scaled;
        scaled = ({7'd0, cnt} * 16'd77) / 16'd192;
        if (sig != COUNT_SIGNATURE) return 7'd33;
        if (scaled < 16'd40)        return 7'd33;
        if (scaled < 16'd45)        return 7'd40;
        if (scaled < 16'd55)        return 7'd50;
        return 7'd66;
    endfunction

    function automatic logic [7:0] window_floor(input logic [6:0] mhz);
        logic [12:0] prod;
        prod = ({6'd0, mhz} * 13'd48) / 13'd66;
        return prod[7:0];
    endfunction

endpackage

// File: rtl/pll_band_classifier.sv
module pll_band_classifier
    import pll_cal_pkg::*;
(
    input  logic [19:0] sig_i,
    input  logic [8:0]  cnt_i,
    output band_info_t  info_o
);
    logic [6:0] mhz;
    logic [7:0] lo;

    always_comb begin
        mhz         = pick_band(sig_i, cnt_i);
        lo          = window_floor(mhz);
        info_o.mhz  = mhz;
        info_o.lo   = lo;
        info_o.hi   = lo + 8'd2;
        info_o.fast = (mhz > 7'd60);
    end
endmodule

// File: rtl/pll_poll_ticker.sv
module pll_poll_ticker #(
    parameter int POLL_INTERVAL = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (POLL_INTERVAL <= 1) begin : g_every_clock
            assign tick_o = run_i;
        end else begin : g_counter
            localparam int TW = $clog2(POLL_INTERVAL + 1);
            localparam logic [TW-1:0] RELOAD = TW'(POLL_INTERVAL - 1);
            logic [TW-1:0] remain;

            always_ff @(posedge clk) begin
                if (rst) begin
                    remain <= RELOAD;
                end else if (restart_i) begin
                    remain <= RELOAD;
                end else if (run_i) begin
                    if (remain == '0) remain <= RELOAD;
                    else              remain <= remain - 1'b1;
                end
            end

            assign tick_o = run_i && (remain == '0);

            // A restart always pushes the next tick at least one clock out
            assert_restart_defers_R6: assert property (@(posedge clk) disable iff (rst)
                restart_i |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/pll_lock_sequencer.sv
module pll_lock_sequencer
    import pll_cal_pkg::*;
#(
    parameter int LOCK_WAIT_POLLS = 20480,
    parameter int HOLD_SAMPLES    = 4096,
    parameter int MAX_ATTEMPTS    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       lock_i,
    input  logic       tick_i,
    input  band_info_t info_i,
    output logic       restart_o,
    output logic       run_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       pass_o,
    output logic       tune_o,
    output band_info_t info_o
);
    localparam int PW = $clog2(LOCK_WAIT_POLLS + 1);
    localparam int HW = $clog2(HOLD_SAMPLES + 1);
    localparam int AW = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(LOCK_WAIT_POLLS - 1);
    localparam logic [HW-1:0] LAST_HOLD = HW'(HOLD_SAMPLES - 1);
    localparam logic [AW-1:0] LAST_ATT  = AW'(MAX_ATTEMPTS - 1);

    cal_state_e  state;
    logic [PW-1:0] poll_cnt;
    logic [HW-1:0] hold_cnt;
    logic [AW-1:0] attempt;
    logic        accept;
    logic        seek_timeout;
    logic        hold_drop;
    logic        attempt_fail;
    logic        last_attempt;
    logic        confirmed;

    always_comb begin
        accept       = (state == ST_IDLE) && start_i;
        seek_timeout = (state == ST_SEEK) && tick_i && !lock_i && (poll_cnt == LAST_POLL);
        hold_drop    = (state == ST_HOLD) && !lock_i;
        attempt_fail = seek_timeout || hold_drop;
        last_attempt = (attempt == LAST_ATT);
        confirmed    = (state == ST_HOLD) && lock_i && (hold_cnt == LAST_HOLD);
        restart_o    = accept || (attempt_fail && !last_attempt);
        run_o        = (state == ST_SEEK);
        busy_o       = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            poll_cnt <= '0;
            hold_cnt <= '0;
            attempt  <= '0;
            tune_o   <= 1'b0;
            done_o   <= 1'b0;
            pass_o   <= 1'b0;
            info_o   <= '0;
        end else if (accept) begin
            info_o   <= info_i;
            tune_o   <= 1'b1;
            done_o   <= 1'b0;
            pass_o   <= 1'b0;
            attempt  <= '0;
            poll_cnt <= '0;
            state    <= ST_SEEK;
        end else if (attempt_fail) begin
            tune_o <= 1'b0;
            if (last_attempt) begin
                done_o <= 1'b1;
                pass_o <= 1'b0;
                state  <= ST_IDLE;
            end else begin
                attempt  <= attempt + 1'b1;
                poll_cnt <= '0;
                state    <= ST_SEEK;
            end
        end else if (confirmed) begin
            tune_o <= 1'b0;
            done_o <= 1'b1;
            pass_o <= 1'b1;
            state  <= ST_IDLE;
        end else begin
            case (state)
                ST_SEEK: if (tick_i) begin
                    if (lock_i) begin
                        hold_cnt <= '0;
                        state    <= ST_HOLD;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_HOLD: hold_cnt <= hold_cnt + 1'b1;
                ST_IDLE: ;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_tune_within_run_R5: assert property (@(posedge clk) disable iff (rst)
        tune_o |-> busy_o);
    assert_pass_needs_done_R7: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> done_o);
    assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    assert_band_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(info_o));
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && !done_o && tune_o));
    assert_attempt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        attempt <= LAST_ATT);
endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
    import pll_cal_pkg::*;
#(
    parameter int POLL_INTERVAL   = 16,
    parameter int LOCK_WAIT_POLLS = 20480,
    parameter int HOLD_SAMPLES    = 4096,
    parameter int MAX_ATTEMPTS    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [31:0] count_word_i,
    input  logic        lock_raw_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        pass_o,
    output logic        tune_en_o,
    output logic [6:0]  band_mhz_o,
    output logic        fast_bus_o,
    output logic [7:0]  win_low_o,
    output logic [7:0]  win_high_o
);
    band_info_t band_now;
    band_info_t band_held;
    logic       tick;
    logic       restart;
    logic       run;
    logic       unused_gap_bits;

    assign unused_gap_bits = ^count_word_i[11:9];

    pll_band_classifier u_classify (
        .sig_i  (count_word_i[31:12]),
        .cnt_i  (count_word_i[8:0]),
        .info_o (band_now)
    );

    pll_poll_ticker #(.POLL_INTERVAL(POLL_INTERVAL)) u_ticker (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .run_i     (run),
        .tick_o    (tick)
    );

    pll_lock_sequencer #(
        .LOCK_WAIT_POLLS (LOCK_WAIT_POLLS),
        .HOLD_SAMPLES    (HOLD_SAMPLES),
        .MAX_ATTEMPTS    (MAX_ATTEMPTS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .lock_i    (lock_raw_i),
        .tick_i    (tick),
        .info_i    (band_now),
        .restart_o (restart),
        .run_o     (run),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .pass_o    (pass_o),
        .tune_o    (tune_en_o),
        .info_o    (band_held)
    );

    assign band_mhz_o = band_held.mhz;
    assign fast_bus_o = band_held.fast;
    assign win_low_o  = band_held.lo;
    assign win_high_o = band_held.hi;
endmodule

// File: tb/pll_lock_qualifier_tb_top.sv
module pll_lock_qualifier_tb_top;
    localparam int POLL  = 4;
    localparam int WAITP = 6;
    localparam int HOLD  = 5;
    localparam int ATT   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cw = '0;
    logic        lock = 1'b0;
    logic        busy, done, pass, tune, fast;
    logic [6:0]  band;
    logic [7:0]  lo, hi;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pll_lock_qualifier #(
        .POLL_INTERVAL(POLL), .LOCK_WAIT_POLLS(WAITP),
        .HOLD_SAMPLES(HOLD), .MAX_ATTEMPTS(ATT)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .count_word_i(cw),
        .lock_raw_i(lock), .busy_o(busy), .done_o(done), .pass_o(pass),
        .tune_en_o(tune), .band_mhz_o(band), .fast_bus_o(fast),
        .win_low_o(lo), .win_high_o(hi)
    );

    function automatic int exp_band(logic [31:0] w);
        int f;
        if (w[31:12] != 20'hABCDE) return 33;
        f = (int'(w[8:0]) * 77) / 192;
        if (f < 40) return 33;
        if (f < 45) return 40;
        if (f < 55) return 50;
        return 66;
    endfunction

    // behavioural reference model
    int m_state, m_since, m_polls, m_hold, m_att;
    int m_band, m_lo, m_hi, m_fast, m_tune, m_done, m_pass;

    task automatic m_fail();
        m_tune = 0;
        m_att++;
        if (m_att == ATT) begin m_state = 0; m_done = 1; m_pass = 0; end
        else begin m_state = 1; m_since = 0; m_polls = 0; end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_since = 0; m_polls = 0; m_hold = 0; m_att = 0;
            m_band = 0; m_lo = 0; m_hi = 0; m_fast = 0; m_tune = 0; m_done = 0; m_pass = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    m_band = exp_band(cw); m_lo = m_band * 48 / 66; m_hi = m_lo + 2;
                    m_fast = (m_band > 60); m_tune = 1; m_done = 0; m_pass = 0;
                    m_att = 0; m_polls = 0; m_since = 0; m_state = 1;
                end
                1: begin
                    m_since++;
                    if (m_since == POLL) begin
                        m_since = 0;
                        if (lock) begin m_state = 2; m_hold = 0; end
                        else begin
                            m_polls++;
                            if (m_polls == WAITP) m_fail();
                        end
                    end
                end
                default: begin
                    if (!lock) m_fail();
                    else begin
                        m_hold++;
                        if (m_hold == HOLD) begin m_tune = 0; m_done = 1; m_pass = 1; m_state = 0; end
                    end
                end
            endcase
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(busy == (m_state != 0), "R9", "busy", busy, m_state != 0);
        chk(done == m_done, "R8", "done", done, m_done);
        chk(pass == m_pass, "R7", "pass", pass, m_pass);
        chk(tune == m_tune, "R5", "tune_en", tune, m_tune);
        chk(band == m_band, "R3", "band", band, m_band);
        chk(lo == m_lo && hi == m_hi, "R4", "window low", lo, m_lo);
        chk(fast == m_fast, "R4", "fast flag", fast, m_fast);
    endtask

    int k, a1, b1, a2, xs;
    logic [31:0] cw_main;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        k++;
        lock = ((k >= a1) && (k < b1)) || (k >= a2);
        if (k == xs) begin start = 1'b1; cw = 32'hABCDE0C8; end
        else begin start = 1'b0; cw = cw_main; end
    endtask

    task automatic run_case(logic [31:0] w, int on1, int off1, int on2, int extra,
                            bit exp_pass, string req);
        int guard;
        a1 = on1; b1 = off1; a2 = on2; xs = extra; k = 0;
        cw_main = w; cw = w; start = 1'b1;
        lock = ((0 >= a1) && (0 < b1)) || (0 >= a2);
        step();
        guard = 0;
        while (m_state != 0 && guard < 2000) begin step(); guard++; end
        chk(done == 1'b1, req, "done at end", done, 1);
        chk(pass == exp_pass, req, "result", pass, exp_pass);
        chk(int'(band) == exp_band(w), "R3", "final band", band, exp_band(w));
        chk(int'(hi) == int'(lo) + 2, "R4", "window gap", hi, lo + 2);
        chk(tune == 1'b0, "R5", "tune low after result", tune, 0);
        step(); step();
    endtask

    initial begin
        a1 = 0; b1 = 0; a2 = 1000000; xs = -1; k = 0; cw_main = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pass && !tune, "R1", "control outs", {busy, done, pass, tune}, 0);
        chk(band == 0 && lo == 0 && hi == 0 && !fast, "R1", "data outs", band, 0);
        // R2: missing signature, immediate lock
        run_case(32'h0000_0000, 0, 0, 0, -1, 1'b1, "R2");
        run_case(32'hABCDF0C8, 0, 0, 0, -1, 1'b1, "R2");
        // R7: lock glitch during confirmation, then retry passes
        run_case(32'hABCDE069, 4, 6, 10, -1, 1'b1, "R7");
        // R8: never locks, start while busy ignored (R9)
        run_case(32'hABCDE063, 0, 0, 1000000, 10, 1'b0, "R8");
        chk(band == 7'd33, "R9", "band after ignored start", band, 33);
        // R6: lock on last poll of first attempt; one clock later needs retry
        run_case(32'hABCDE064, 0, 0, POLL * WAITP, -1, 1'b1, "R6");
        run_case(32'hABCDE070, 0, 0, POLL * WAITP + 1, -1, 1'b1, "R6");
        // R3 boundaries and R7 exact hold length
        run_case(32'hABCDE071, 0, 0, 0, -1, 1'b1, "R3");
        run_case(32'hABCDE089, 4, 9, 30, -1, 1'b1, "R7");
        run_case(32'hABCDE08A, 4, 10, 1000000, -1, 1'b1, "R7");
        run_case(32'hABCDE1FF, 0, 0, 0, -1, 1'b1, "R4");
        chk(fast == 1'b1, "R4", "fast for 66", fast, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule